// File: doc/BRIEF.md
# Converter Fault Supervisor with Timed Restart

This block watches the comparator outputs of a flyback power-factor controller, qualifies each fault with a rule of its own, and latches a shutdown when any one of them holds. The qualifiers are of five kinds:

- a millisecond window for a collapsed output;
- a count of switching cycles for feedback over-voltage;
- a clock-count window for supply over-voltage;
- a count of consecutive line zero-cross intervals for overload;
- a check on the first gate pulse only for a shorted sense resistor.

Over-current and over-temperature trip at once.

A latched fault disables the gate and raises a hold request that keeps the supply regulator active. After a fixed number of millisecond ticks the block returns to its run state and clears the fault code. A thermal fault holds on past the timed hold until the cool comparator reports that the die has cooled. The fault code gives the first fault that latched.

Top module: `prot_supervisor`

## Requirements
- R1: After a synchronous active-low reset, gate_disable and hold_req are 0 and fault_code is 0.
- R2: cs_ocp high on any sampled clock edge while running latches code 1 at that edge.
- R3: vdd_high high on VDD_OV_CLKS (2500) consecutive clock edges latches code 2. A single low cycle restarts the count.
- R4: fb_high high at FBOV_CYCLES (4) consecutive gate_end strobes latches code 3. fb_high low on any cycle clears the count.
- R5: fb_low high across SHORT_MS (35) ms_tick pulses without a break latches code 4. fb_low low on any cycle clears the count.
- R6: While first_cycle is high, a gate_end strobe with no cs_min seen since first_cycle rose latches code 5. If cs_min was seen, no trip occurs. When first_cycle is low, gate_end is ignored for this check.
- R7: An interval is bounded by zc_pulse, and the first interval starts at reset. When OVERLOAD_ZC (60) consecutive intervals each contain a cs_limit pulse, code 6 latches at the closing zc_pulse. An interval without such a pulse clears the count.
- R8: temp_hot latches code 7. After the timed hold, the block stays held until temp_cool is high.
- R9: While a fault is latched, gate_disable and hold_req are both 1. They stay 1 through HOLD_MS (3000) ms_tick pulses and drop one clock after the last of those pulses, and fault_code then returns to 0.
- R10: The latched code stays unchanged until release, and later trips are ignored. If several faults trip on the same edge, the lowest code wins. Codes: 1 over-current, 2 supply over-voltage, 3 feedback over-voltage, 4 output short, 5 sense short, 6 overload, 7 thermal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| gate_end | input | 1 | One-cycle strobe at the end of each gate on-time |
| first_cycle | input | 1 | High during the first switching cycle |
| zc_pulse | input | 1 | One-cycle pulse at each line zero-cross |
| fb_low | input | 1 | Feedback sample below the short level |
| fb_high | input | 1 | Feedback sample above the over-voltage level |
| vdd_high | input | 1 | Supply above its over-voltage level |
| cs_ocp | input | 1 | Current sense above the over-current level |
| cs_limit | input | 1 | Current sense reached the cycle limit |
| cs_min | input | 1 | Current sense above the minimum level |
| temp_hot | input | 1 | Die temperature above the trip level |
| temp_cool | input | 1 | Die temperature below the release level |
| gate_disable | output | 1 | Switching stopped |
| hold_req | output | 1 | Keep supply regulation active |
| fault_code | output | 3 | Code of the latched fault, 0 when running |

## Verification
Each qualifier decides trip combinationally on the edge where its last qualifying input is sampled. The latch register shows the fault one clock later. Release comes two edges after the final hold tick: one edge to count the tick and one to leave the hold. The bench drives inputs on falling edges and waits two falling edges after each stimulus before it samples, so every sample falls after the edge that can change the output. Each window is tested at its limit and one step short of it, and also with a one-cycle break inside it.

// File: rtl/prot_sup_pkg.sv
// Shared fault codes and supervisor state encoding.
package prot_sup_pkg;
    localparam int NUM_FAULTS = 7;

    typedef enum logic [2:0] {
        FLT_NONE         = 3'd0,
        FLT_OCP          = 3'd1,
        FLT_SUPPLY_OV    = 3'd2,
        FLT_FB_OV        = 3'd3,
        FLT_OUT_SHORT    = 3'd4,
        FLT_RSENSE_SHORT = 3'd5,
        FLT_OVERLOAD     = 3'd6,
        FLT_THERMAL      = 3'd7
    } fault_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } sup_state_e;
endpackage

// File: rtl/prot_qual_streak.sv
// Consecutive-condition qualifier. Counts step pulses while cond stays high
// and reports hit on the step that completes LIMIT of them.
// Assumes: cond low or clr on any cycle clears the run.
module prot_qual_streak #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cond,
    input  logic step,
    output logic hit
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_q;

    assign hit = cond & step & (cnt_q == CW'(LIMIT - 1));

    // Advance the run on each step, restart it when the condition breaks.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !cond) begin
            cnt_q <= '0;
        end else if (step && !hit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/prot_zc_streak.sv
// Overload qualifier. An interval is closed by each zero-cross pulse. It
// counts the intervals in a row that held at least one limit event, and
// reports hit at the zero-cross that closes interval number LIMIT.
// Assumes: the first interval opens at reset or at clr.
module prot_zc_streak #(
    parameter int LIMIT = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic zc,
    input  logic evt,
    output logic hit
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_q;
    logic          ev_q;
    logic          seen;

    assign seen = ev_q | evt;
    assign hit  = zc & seen & (cnt_q == CW'(LIMIT - 1));

    // Remember an event inside the open interval; score it at zero-cross.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            ev_q  <= 1'b0;
        end else if (zc) begin
            ev_q  <= 1'b0;
            cnt_q <= seen ? (hit ? cnt_q : cnt_q + 1'b1) : '0;
        end else begin
            ev_q  <= seen;
        end
    end
endmodule

// File: rtl/prot_rsense_check.sv
// Sense-resistor short check. During the first switching cycle it watches
// for current sense to pass its minimum level. If the on-time ends without
// that, it reports hit.
// Assumes: gate_end marks the end of the on-time.
module prot_rsense_check (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic first_cycle,
    input  logic gate_end,
    input  logic cs_min,
    output logic hit
);
    logic seen_q;

    assign hit = first_cycle & gate_end & ~(seen_q | cs_min);

    // Record that the sense level was reached during the first cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !first_cycle) begin
            seen_q <= 1'b0;
        end else if (cs_min) begin
            seen_q <= 1'b1;
        end
    end
endmodule

// File: rtl/prot_restart_ctrl.sv
// Fault latch and restart timer. It latches the lowest-coded trip, then
// holds for HOLD_MS millisecond ticks. A thermal fault also waits for the
// cool flag before release.
// Assumes: trip bit i stands for fault code i+1.
module prot_restart_ctrl
    import prot_sup_pkg::*;
#(
    parameter int HOLD_MS = 3000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FAULTS-1:0] trip_vec,
    input  logic                  ms_tick,
    input  logic                  temp_cool,
    output logic                  in_hold,
    output fault_e                code
);
    localparam int HW = $clog2(HOLD_MS + 1);

    sup_state_e   state_q;
    fault_e       code_q;
    fault_e       pick;
    logic [HW-1:0] hcnt_q;
    logic          hold_done;
    logic          release_ok;

    // Priority pick: the lowest set bit wins.
    always_comb begin
        pick = FLT_NONE;
        for (int i = NUM_FAULTS - 1; i >= 0; i--) begin
            if (trip_vec[i]) pick = fault_e'(i + 1);
        end
    end

    assign hold_done  = (hcnt_q == HW'(HOLD_MS));
    assign release_ok = hold_done && ((code_q != FLT_THERMAL) || temp_cool);

    // Run/hold sequencing with the millisecond hold counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            code_q  <= FLT_NONE;
            hcnt_q  <= '0;
        end else if (state_q == ST_RUN) begin
            hcnt_q <= '0;
            if (|trip_vec) begin
                state_q <= ST_HOLD;
                code_q  <= pick;
            end
        end else if (release_ok) begin
            state_q <= ST_RUN;
            code_q  <= FLT_NONE;
            hcnt_q  <= '0;
        end else if (ms_tick && !hold_done) begin
            hcnt_q <= hcnt_q + 1'b1;
        end
    end

    assign in_hold = (state_q == ST_HOLD);
    assign code    = code_q;
endmodule

// File: rtl/prot_supervisor.sv
// Converter protection supervisor. Qualifies seven fault flags, latches the
// first trip, stops switching and asks for supply regulation during the
// timed restart hold. All inputs are synchronous single-bit flags or pulses.
module prot_supervisor
    import prot_sup_pkg::*;
#(
    parameter int SHORT_MS    = 35,
    parameter int FBOV_CYCLES = 4,
    parameter int VDD_OV_CLKS = 2500,
    parameter int OVERLOAD_ZC = 60,
    parameter int HOLD_MS     = 3000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       gate_end,
    input  logic       first_cycle,
    input  logic       zc_pulse,
    input  logic       fb_low,
    input  logic       fb_high,
    input  logic       vdd_high,
    input  logic       cs_ocp,
    input  logic       cs_limit,
    input  logic       cs_min,
    input  logic       temp_hot,
    input  logic       temp_cool,
    output logic       gate_disable,
    output logic       hold_req,
    output logic [2:0] fault_code
);
    logic [NUM_FAULTS-1:0] trip_vec;
    logic                  in_hold;
    fault_e                code;
    logic                  hit_vdd;
    logic                  hit_fbov;
    logic                  hit_short;
    logic                  hit_rsense;
    logic                  hit_olp;

    // Supply over-voltage: window counted in clocks.
    prot_qual_streak #(.LIMIT(VDD_OV_CLKS)) u_vdd_ov (
        .clk(clk), .rst_n(rst_n), .clr(in_hold),
        .cond(vdd_high), .step(1'b1), .hit(hit_vdd)
    );

    // Feedback over-voltage: counted in switching cycles.
    prot_qual_streak #(.LIMIT(FBOV_CYCLES)) u_fb_ov (
        .clk(clk), .rst_n(rst_n), .clr(in_hold),
        .cond(fb_high), .step(gate_end), .hit(hit_fbov)
    );

    // Output short: counted in milliseconds.
    prot_qual_streak #(.LIMIT(SHORT_MS)) u_short (
        .clk(clk), .rst_n(rst_n), .clr(in_hold),
        .cond(fb_low), .step(ms_tick), .hit(hit_short)
    );

    prot_rsense_check u_rsense (
        .clk(clk), .rst_n(rst_n), .clr(in_hold),
        .first_cycle(first_cycle), .gate_end(gate_end),
        .cs_min(cs_min), .hit(hit_rsense)
    );

    prot_zc_streak #(.LIMIT(OVERLOAD_ZC)) u_overload (
        .clk(clk), .rst_n(rst_n), .clr(in_hold),
        .zc(zc_pulse), .evt(cs_limit), .hit(hit_olp)
    );

    // Gather trips in code order (bit i = code i+1).
    assign trip_vec = {temp_hot, hit_olp, hit_rsense, hit_short,
                       hit_fbov, hit_vdd, cs_ocp};

    prot_restart_ctrl #(.HOLD_MS(HOLD_MS)) u_restart (
        .clk(clk), .rst_n(rst_n), .trip_vec(trip_vec),
        .ms_tick(ms_tick), .temp_cool(temp_cool),
        .in_hold(in_hold), .code(code)
    );

    assign gate_disable = in_hold;
    assign hold_req     = in_hold;
    assign fault_code   = code;
endmodule

// File: rtl/prot_sup_checker.sv
// Temporal checks on the supervisor ports, bound to every instance.
module prot_sup_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_ocp,
    input logic       temp_cool,
    input logic       gate_disable,
    input logic       hold_req,
    input logic [2:0] fault_code
);
    logic was_rst;

    // Note a reset edge so the outputs can be checked after it.
    always_ff @(posedge clk) was_rst <= !rst_n;

    // Check the outputs half a clock after a reset edge.
    always @(negedge clk) begin
        if (was_rst) begin
            AST_RESET_CLEAN: assert (!gate_disable && !hold_req && fault_code == 3'd0); // R1
        end
    end

    AST_OCP_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_ocp && !gate_disable) |=> (gate_disable && fault_code == 3'd1)); // R2

    AST_HELD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        gate_disable |-> (hold_req && fault_code != 3'd0)); // R9

    AST_RUN_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_disable |-> (fault_code == 3'd0)); // R9

    AST_THERM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_disable && fault_code == 3'd7 && !temp_cool) |=> gate_disable); // R8

    AST_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_disable && $past(gate_disable)) |-> (fault_code == $past(fault_code))); // R10
endmodule

bind prot_supervisor prot_sup_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs_ocp(cs_ocp), .temp_cool(temp_cool),
    .gate_disable(gate_disable), .hold_req(hold_req), .fault_code(fault_code)
);

// File: tb/prot_supervisor_test.sv
module prot_supervisor_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 0, gate_end = 0, first_cycle = 0, zc_pulse = 0;
    logic fb_low = 0, fb_high = 0, vdd_high = 0, cs_ocp = 0, cs_limit = 0;
    logic cs_min = 0, temp_hot = 0, temp_cool = 1;
    logic       gate_disable, hold_req;
    logic [2:0] fault_code;
    int nchk = 0;
    int nbad = 0;
    bit done = 0;

    always #2 clk = ~clk;  // 250 MHz

    prot_supervisor uut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .gate_end(gate_end),
        .first_cycle(first_cycle), .zc_pulse(zc_pulse), .fb_low(fb_low),
        .fb_high(fb_high), .vdd_high(vdd_high), .cs_ocp(cs_ocp),
        .cs_limit(cs_limit), .cs_min(cs_min), .temp_hot(temp_hot),
        .temp_cool(temp_cool), .gate_disable(gate_disable),
        .hold_req(hold_req), .fault_code(fault_code)
    );

    // kind: 0 ocp, 1 supply ov clocks, 2 fb ov strobes, 3 short ticks,
    //       4 first pulse (n=1 sense seen), 5 overload intervals, 6 thermal
    typedef struct packed {
        logic [3:0]  kind;
        logic [15:0] n;
        logic [2:0]  exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 16'd1,    3'd1},
        '{4'd1, 16'd2500, 3'd2},
        '{4'd1, 16'd2499, 3'd0},
        '{4'd2, 16'd4,    3'd3},
        '{4'd2, 16'd3,    3'd0},
        '{4'd3, 16'd35,   3'd4},
        '{4'd3, 16'd34,   3'd0},
        '{4'd4, 16'd0,    3'd5},
        '{4'd4, 16'd1,    3'd0},
        '{4'd5, 16'd60,   3'd6},
        '{4'd5, 16'd59,   3'd0},
        '{4'd6, 16'd1,    3'd7}
    };

    function automatic string req_of(input logic [3:0] k);
        case (k)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3: return "R5";
            4'd4: return "R6";
            4'd5: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input int exp_code);
        chk(req, fault_code, exp_code);
        chk(req, gate_disable, exp_code != 0);
        chk(req, hold_req, exp_code != 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; ms_tick = 0; gate_end = 0; first_cycle = 0; zc_pulse = 0;
        fb_low = 0; fb_high = 0; vdd_high = 0; cs_ocp = 0; cs_limit = 0;
        cs_min = 0; temp_hot = 0; temp_cool = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_tick();
        ms_tick = 1; @(negedge clk); ms_tick = 0; @(negedge clk);
    endtask

    task automatic pulse_gend();
        gate_end = 1; @(negedge clk); gate_end = 0; @(negedge clk);
    endtask

    task automatic olp_interval(input bit with_evt);
        if (with_evt) begin
            cs_limit = 1; @(negedge clk); cs_limit = 0;
        end
        @(negedge clk);
        zc_pulse = 1; @(negedge clk); zc_pulse = 0;
    endtask

    task automatic run_vec(input vec_t v);
        case (v.kind)
            4'd0: begin cs_ocp = 1; @(negedge clk); cs_ocp = 0; end
            4'd1: begin vdd_high = 1; repeat (int'(v.n)) @(negedge clk); vdd_high = 0; end
            4'd2: begin fb_high = 1; for (int i = 0; i < int'(v.n); i++) pulse_gend(); end
            4'd3: begin fb_low = 1; for (int i = 0; i < int'(v.n); i++) pulse_tick(); end
            4'd4: begin
                first_cycle = 1;
                @(negedge clk);
                if (v.n != 0) begin cs_min = 1; @(negedge clk); cs_min = 0; end
                @(negedge clk);
                gate_end = 1; @(negedge clk); gate_end = 0;
                first_cycle = 0;
            end
            4'd5: for (int i = 0; i < int'(v.n); i++) olp_interval(1'b1);
            default: begin temp_cool = 0; temp_hot = 1; @(negedge clk); temp_hot = 0; end
        endcase
        settle();
    endtask

    initial begin
        // R1: reset state
        do_reset();
        chk_out("R1", 0);

        // Table walk: one fault kind per entry, at and just short of its limit
        for (int i = 0; i < NV; i++) begin
            do_reset();
            run_vec(VECS[i]);
            chk_out(req_of(VECS[i].kind), int'(VECS[i].exp));
            fb_high = 0; fb_low = 0;
        end

        // R3: a one-cycle drop restarts the supply window
        do_reset();
        vdd_high = 1; repeat (2000) @(negedge clk);
        vdd_high = 0; @(negedge clk);
        vdd_high = 1; repeat (2000) @(negedge clk);
        vdd_high = 0; settle();
        chk_out("R3", 0);

        // R4: a break in the feedback-high run clears the cycle count
        do_reset();
        fb_high = 1; repeat (3) pulse_gend();
        fb_high = 0; @(negedge clk);
        fb_high = 1; repeat (3) pulse_gend();
        settle(); chk_out("R4", 0);
        fb_high = 0;

        // R5: a break in the low-feedback run clears the ms count
        do_reset();
        fb_low = 1; repeat (34) pulse_tick();
        fb_low = 0; @(negedge clk);
        fb_low = 1; repeat (34) pulse_tick();
        settle(); chk_out("R5", 0);
        fb_low = 0;

        // R6: gate_end outside the first cycle does not trip
        do_reset();
        pulse_gend(); settle();
        chk_out("R6", 0);

        // R7: one empty interval clears the overload run
        do_reset();
        for (int i = 0; i < 59; i++) olp_interval(1'b1);
        olp_interval(1'b0);
        for (int i = 0; i < 59; i++) olp_interval(1'b1);
        settle(); chk_out("R7", 0);
        olp_interval(1'b1);
        settle(); chk_out("R7", 6);

        // R9: hold lasts exactly HOLD_MS ticks
        do_reset();
        cs_ocp = 1; @(negedge clk); cs_ocp = 0;
        repeat (2999) pulse_tick();
        settle(); chk_out("R9", 1);
        pulse_tick(); settle();
        chk_out("R9", 0);

        // R8: thermal hold waits for the cool flag
        do_reset();
        temp_cool = 0; temp_hot = 1; @(negedge clk); temp_hot = 0;
        repeat (3000) pulse_tick();
        repeat (10) @(negedge clk);
        chk_out("R8", 7);
        temp_cool = 1; settle();
        chk_out("R8", 0);

        // R10: a later trip does not replace the latched code
        do_reset();
        cs_ocp = 1; @(negedge clk); cs_ocp = 0;
        temp_cool = 0; temp_hot = 1; @(negedge clk); temp_hot = 0; temp_cool = 1;
        settle(); chk_out("R10", 1);

        // R10: simultaneous trips, lowest code wins
        do_reset();
        temp_hot = 1; fb_high = 1; gate_end = 1; first_cycle = 1;
        @(negedge clk);
        temp_hot = 0; fb_high = 0; gate_end = 0; first_cycle = 0;
        settle(); chk_out("R10", 5);

        done = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end
endmodule